// File: doc/BRIEF.md
# Register-access SPI master with address-dependent idle gap

This block is the host side of a byte-oriented register link to a line-interface device. A client hands it one request at a time over a valid/ready command port: a read or write flag, a 7-bit register address and, for writes, a data byte. The block then runs one SPI frame in mode 0. Chip select is active low. A control byte goes out first, holding the read flag in its top bit and the address below it. A data byte follows. For a read, the byte sampled from the device comes back on a one-cycle response strobe.

Some control registers in the device, at addresses 0x12 to 0x19 and at 0x1F, only accept an access if chip select has been idle high for a long time since the previous frame ended. That time is 500 µs at the device pins. The block turns it into a count of system clock cycles from two parameters: the clock rate in kHz and the guard time in µs. A request for any other address only has to wait a short parameterised gap. The idle time is counted from every rising edge of chip select, whatever address the previous frame used. A request that arrives too early is held with ready low until its own gap has passed. No PLL lock and no PCM clock are needed, because the block depends only on the system clock.

Top module: `spi_gap_master`

## Requirements
- R1: After reset, spi_csn is 1, spi_sclk is 0, rsp_valid is 0, and cmd_ready is 1 for every address, because no previous frame needs a gap.
- R2: Each frame has exactly 16 rising edges of spi_sclk while spi_csn is low. The first 8 bits on spi_mosi, sent MSB first, form the control byte. Bit 7 of the control byte is the read flag (1 = read, 0 = write) and bits 6..0 are cmd_addr.
- R3: SPI mode 0 is used. spi_sclk is 0 whenever spi_csn is 1, and spi_mosi does not change while spi_sclk is high.
- R4: The second byte on spi_mosi, sent MSB first, is cmd_wdata for a write and 0x00 for a read.
- R5: spi_miso is sampled on the last 8 rising edges of spi_sclk, MSB first. The result appears on rsp_rdata together with a one-cycle rsp_valid pulse in the cycle right after the edge on which spi_csn goes high.
- R6: Each spi_sclk half period lasts HALF_DIV clock cycles. The first rising edge comes HALF_DIV cycles after spi_csn falls. spi_csn stays low for 33*HALF_DIV cycles.
- R7: A request to a guarded address (0x12 to 0x19, or 0x1F) lowers spi_csn only after spi_csn has been high for at least LONG_GAP = CLK_KHZ*GUARD_US/1000 cycles. If the request is already waiting when that count is reached, spi_csn falls after exactly LONG_GAP cycles.
- R8: A request to any other address lowers spi_csn after at least SHORT_GAP high cycles. If the request is already waiting, spi_csn falls after exactly SHORT_GAP cycles. If the gap has already passed, the frame starts on the handshake edge.
- R9: The gap count restarts at every rising edge of spi_csn, whatever address the previous frame used. A guarded request that directly follows an unguarded frame still waits the full LONG_GAP.
- R10: cmd_ready is 0 while a frame is in progress (spi_csn low) and while the gap for the presented address has not passed. spi_csn falls only on a cycle where cmd_valid and cmd_ready are both high.
- R11: The first request after reset is accepted on the first clock edge at which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A request is presented |
| cmd_ready | output | 1 | Request accepted on this edge if cmd_valid is high |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | One-cycle pulse when a frame completes |
| rsp_rdata | output | 8 | Byte sampled from spi_miso during the data phase |
| spi_csn | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with HALF_DIV=2, SHORT_GAP=4, CLK_KHZ=80 and GUARD_US=500. This gives a 40-cycle guarded gap, so a frame lasts 66 cycles and both gap limits can be reached in a few dozen cycles. With these values the bench can sweep all addresses from 0x00 to 0x25, alternating reads and writes. Before each request it waits an idle delay between 0 and 52 cycles, so some requests arrive before their gap has passed and some after. For every frame it predicts the chip-select high time as the larger of the required gap and the natural issue latency. Directed sequences that switch between guarded and unguarded addresses exercise the gap count restarting at every frame end.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_TAIL  = 2'd2
  } eng_state_t;

  // Addresses whose access needs the long idle gap before chip select falls.
  function automatic logic addr_guarded(input logic [ADDR_W-1:0] a);
    return ((a >= ADDR_W'(8'h12)) && (a <= ADDR_W'(8'h19))) || (a == ADDR_W'(8'h1F));
  endfunction

  // Serial frame: read flag, address, then data (zero for reads).
  function automatic logic [FRAME_W-1:0] build_frame(input logic rd,
                                                     input logic [ADDR_W-1:0] a,
                                                     input logic [DATA_W-1:0] wd);
    return {rd, a, (rd ? {DATA_W{1'b0}} : wd)};
  endfunction

  // Guard time in clock cycles: kHz * us / 1000.
  function automatic int guard_cycles(input int clk_khz, input int guard_us);
    return (clk_khz * guard_us) / 1000;
  endfunction

endpackage

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int LONG_GAP  = 40,
  parameter int SHORT_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn,
  input  logic guarded,
  output logic gap_ok
);
  localparam int SAT = (LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP;
  localparam int CW  = $clog2(SAT + 1) + 1;

  // hi_cnt = number of cycles chip select has been high, including this one.
  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hi_cnt <= CW'(SAT);
    else if (!csn)               hi_cnt <= CW'(1);
    else if (hi_cnt < CW'(SAT))  hi_cnt <= hi_cnt + CW'(1);
  end

  assign need   = guarded ? CW'(LONG_GAP) : CW'(SHORT_GAP);
  assign gap_ok = csn && (hi_cnt >= need);

endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_gap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               tick,
  input  logic               miso,
  output logic               csn,
  output logic               sclk,
  output logic               mosi,
  output logic               run,
  output logic               done,
  output logic [DATA_W-1:0]  rdata
);
  localparam int BW = $clog2(FRAME_W);

  eng_state_t         state;
  logic [FRAME_W-1:0] tx_sh;
  logic [DATA_W-1:0]  rx_sh;
  logic [BW-1:0]      bit_cnt;

  assign run  = (state != ENG_IDLE);
  assign mosi = tx_sh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_cnt <= '0;
      csn     <= 1'b1;
      sclk    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ENG_IDLE: begin
          if (start) begin
            tx_sh   <= frame_in;
            bit_cnt <= '0;
            csn     <= 1'b0;
            state   <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk  <= 1'b1;
              rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end else begin
              sclk  <= 1'b0;
              tx_sh <= tx_sh << 1;
              if (bit_cnt == BW'(FRAME_W - 1)) state <= ENG_TAIL;
              else                             bit_cnt <= bit_cnt + BW'(1);
            end
          end
        end
        ENG_TAIL: begin
          if (tick) begin
            csn   <= 1'b1;
            done  <= 1'b1;
            rdata <= rx_sh;
            state <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_gap_master.sv
module spi_gap_master
  import spi_gap_pkg::*;
#(
  parameter int CLK_KHZ   = 250000,
  parameter int GUARD_US  = 500,
  parameter int SHORT_GAP = 4,
  parameter int HALF_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              spi_csn,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int LONG_GAP = guard_cycles(CLK_KHZ, GUARD_US);

  // Named internal events, visible to the bound checker.
  logic guarded_req;
  logic gap_ok;
  logic eng_run;
  logic half_tick;
  logic frame_start;
  logic frame_done;
  logic [FRAME_W-1:0] frame_word;

  assign guarded_req = addr_guarded(cmd_addr);
  assign cmd_ready   = !eng_run && gap_ok;
  assign frame_start = cmd_valid && cmd_ready;
  assign frame_word  = build_frame(cmd_read, cmd_addr, cmd_wdata);
  assign rsp_valid   = frame_done;

  spi_gap_timer #(
    .LONG_GAP  (LONG_GAP),
    .SHORT_GAP (SHORT_GAP)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .csn     (spi_csn),
    .guarded (guarded_req),
    .gap_ok  (gap_ok)
  );

  spi_half_tick #(
    .HALF_DIV (HALF_DIV)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (eng_run),
    .tick  (half_tick)
  );

  spi_frame_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (frame_start),
    .frame_in (frame_word),
    .tick     (half_tick),
    .miso     (spi_miso),
    .csn      (spi_csn),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .run      (eng_run),
    .done     (frame_done),
    .rdata    (rsp_rdata)
  );

endmodule

// File: rtl/spi_gap_master_chk.sv
module spi_gap_master_chk #(
  parameter int LONG_GAP  = 40,
  parameter int SHORT_GAP = 4,
  parameter int HALF_DIV  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic frame_start,
  input logic guarded_req,
  input logic rsp_valid,
  input logic spi_csn,
  input logic spi_sclk,
  input logic spi_mosi
);
  localparam int SAT = (LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP;
  localparam int LOW_LEN = 33 * HALF_DIV;

  int hi_run;
  int lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= SAT;
      lo_run <= 0;
    end else begin
      hi_run <= spi_csn ? ((hi_run < SAT) ? hi_run + 1 : hi_run) : 0;
      lo_run <= spi_csn ? 0 : ((lo_run < LOW_LEN + 1) ? lo_run + 1 : lo_run);
    end
  end

  AST_GUARDED_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && guarded_req) |-> (hi_run >= LONG_GAP - 1)); // R7
  AST_PLAIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (hi_run >= SHORT_GAP - 1)); // R8
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sclk); // R3
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_csn && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R3
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_csn |-> !cmd_ready); // R10
  AST_START_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_csn) |-> $past(frame_start)); // R10
  AST_RSP_WITH_CSN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(spi_csn)); // R5
  AST_CSN_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_csn) |-> (lo_run == LOW_LEN)); // R6

endmodule

bind spi_gap_master spi_gap_master_chk #(
  .LONG_GAP  (LONG_GAP),
  .SHORT_GAP (SHORT_GAP),
  .HALF_DIV  (HALF_DIV)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready   (cmd_ready),
  .frame_start (frame_start),
  .guarded_req (guarded_req),
  .rsp_valid   (rsp_valid),
  .spi_csn     (spi_csn),
  .spi_sclk    (spi_sclk),
  .spi_mosi    (spi_mosi)
);

// File: tb/test_spi_gap_master.sv
`timescale 1ns/1ps
module test_spi_gap_master;
  localparam int HD    = 2;
  localparam int SG    = 4;
  localparam int LG    = 40;   // 80 kHz * 500 us / 1000
  localparam int LOWL  = 33 * HD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic cmd_read = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic rsp_valid;
  logic [7:0] rsp_rdata;
  logic spi_csn, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  spi_gap_master #(
    .CLK_KHZ(80), .GUARD_US(500), .SHORT_GAP(SG), .HALF_DIV(HD)
  ) i_spi_gap_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .spi_csn(spi_csn),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- monitor and device model, at falling clock edges ----------
  logic prev_csn = 1'b1, prev_sclk = 1'b0;
  int hi_len = 0, lo_len = 0, pre_len = 0, rises = 0;
  logic [15:0] got = '0;
  int last_gap = 0, last_low = 0, last_rises = 0, last_first = 0;
  logic [15:0] last_frame = '0;
  logic [7:0] dev_resp = '0;
  int busy_ready = 0, sclk_idle_bad = 0, mosi_move = 0;
  logic hold_mosi = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_csn && spi_sclk) sclk_idle_bad++;
      if (!spi_csn && cmd_ready) busy_ready++;
      if (!spi_csn && spi_sclk && prev_sclk && (spi_mosi != hold_mosi)) mosi_move++;
      if (!spi_csn && prev_csn) begin
        last_gap = hi_len; lo_len = 0; pre_len = 0; rises = 0; got = '0;
      end
      if (spi_csn) hi_len++; else hi_len = 0;
      if (!spi_csn) begin
        lo_len++;
        if (rises == 0 && !spi_sclk) pre_len++;
        if (spi_sclk && !prev_sclk) begin
          if (rises == 0) last_first = pre_len;
          got = {got[14:0], spi_mosi};
          rises++;
          hold_mosi = spi_mosi;
        end
        if (!spi_sclk && prev_sclk && rises >= 8 && rises < 16)
          spi_miso = dev_resp[15 - rises];
      end
      if (spi_csn && !prev_csn) begin
        last_low = lo_len; last_rises = rises; last_frame = got;
      end
      prev_csn = spi_csn;
      prev_sclk = spi_sclk;
    end
  end

  // ---------------- request driver ------------------------------------------
  task automatic do_txn(input bit rd, input logic [6:0] a, input logic [7:0] wd,
                        input int idle, input bit first);
    int probes;
    int need;
    int exp_gap;
    logic [15:0] exp_frame;
    logic [7:0] resp;
    bit g;
    g = ((a >= 7'h12) && (a <= 7'h19)) || (a == 7'h1F);
    need = g ? LG : SG;
    exp_gap = (need > 2 + idle) ? need : 2 + idle;
    resp = 8'(a * 3 + 8'h5A);
    exp_frame = {rd, a, (rd ? 8'h00 : wd)};
    repeat (idle) @(negedge clk);
    dev_resp = resp;
    cmd_valid = 1'b1; cmd_read = rd; cmd_addr = a; cmd_wdata = wd;
    probes = 0;
    forever begin
      #1;
      if (cmd_ready) break;
      probes++;
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    if (rd) chk(rsp_rdata == resp, "R5 read data", rsp_rdata, resp);
    @(negedge clk);
    chk(last_frame[15:8] == exp_frame[15:8], "R2 control byte", last_frame[15:8], exp_frame[15:8]);
    chk(last_frame[7:0] == exp_frame[7:0], "R4 data byte", last_frame[7:0], exp_frame[7:0]);
    chk(last_rises == 16, "R2 sclk rises", last_rises, 16);
    chk(last_low == LOWL, "R6 csn low length", last_low, LOWL);
    chk(last_first == HD, "R6 first rise delay", last_first, HD);
    if (first) chk(probes == 0, "R11 first request accepted at once", probes, 0);
    else if (g) chk(last_gap == exp_gap, "R7 guarded gap", last_gap, exp_gap);
    else chk(last_gap == exp_gap, "R8 short gap", last_gap, exp_gap);
  endtask

  // ---------------- watchdog ------------------------------------------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- main sequence -------------------------------------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmd_addr = 7'h15;
    #1;
    chk(spi_csn == 1'b1, "R1 csn idle", spi_csn, 1);
    chk(spi_sclk == 1'b0, "R1 sclk idle", spi_sclk, 0);
    chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
    chk(cmd_ready == 1'b1, "R1 ready for guarded address", cmd_ready, 1);
    @(negedge clk);

    // First request after reset to a guarded register: no wait (R11).
    do_txn(1'b1, 7'h12, 8'h00, 0, 1'b1);

    // R9: gap restarts on every frame end, whatever the address was.
    do_txn(1'b0, 7'h1F, 8'hC3, 0, 1'b0);   // guarded after guarded
    do_txn(1'b1, 7'h20, 8'h00, 0, 1'b0);   // short after guarded
    do_txn(1'b0, 7'h13, 8'h96, 0, 1'b0);   // R9 guarded after short
    do_txn(1'b1, 7'h1E, 8'h00, 5, 1'b0);   // short gap already passed
    do_txn(1'b1, 7'h19, 8'h00, 20, 1'b0);  // R9 guarded, partly waited

    // Sweep of the whole address range with varying idle delays.
    for (int a = 0; a <= 8'h25; a++) begin
      do_txn(a[0], 7'(a), 8'(a ^ 8'h3C), (a * 7) % 53, 1'b0);
    end

    chk(busy_ready == 0, "R10 ready low while busy", busy_ready, 0);
    chk(sclk_idle_bad == 0, "R3 sclk low while deselected", sclk_idle_bad, 0);
    chk(mosi_move == 0, "R3 mosi steady while sclk high", mosi_move, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule